// File: doc/BRIEF.md
# Access Indicator Stretcher and Slot Reset Generator

This block sits beside the bus front end of a carrier card that hosts five plug-in module slots (A to E) and a small bank of carrier registers. Each of the six targets has a select strobe that is high for the cycle or cycles in which it is addressed. A strobe that is one clock long would be invisible on an indicator lamp, so every strobe starts a retriggerable counter, and the counter holds the matching indicator output on for a set number of clock cycles. Accesses that keep arriving keep the lamp lit.

The same counter structure makes per-slot module resets. Software writes a five-bit reset command, and each set bit starts a long one-shot for its slot. It may set one bit or all five in a single write. Each slot's reset line is the system reset ORed with that slot's one-shot. The current level of all five reset lines is also presented as a status word, so software can poll it until every line has dropped.

All state is cleared by a synchronous, active-high system reset. All outputs come straight from flops.

Top module: `access_led_reset_ctrl`

## Requirements
- R1: While `sys_rst` is high at a clock edge, after that edge all six `led_o` bits are 0 and all five `mod_rst_o` and `rst_status_o` bits are 1.
- R2: A high `sel_i[i]` at an edge drives `led_o[i]` high from that edge for exactly `LED_CYCLES` cycles. Bits 0 to 4 are slots A to E, and bit 5 is the carrier registers.
- R3: A select seen while an indicator pulse is running restarts the full `LED_CYCLES` count. A select held high keeps the indicator on until `LED_CYCLES` cycles after its last high edge.
- R4: The six indicator one-shots are independent: a select on one target never changes another target's `led_o` bit.
- R5: A write (`rst_wr_en` high at an edge) with `rst_wr_data[i]` set drives `mod_rst_o[i]` high from that edge for exactly `RST_CYCLES` cycles. Bits 0 to 4 are slots A to E.
- R6: A single write with all five data bits set starts all five slot resets together.
- R7: Data bits that are clear in a write, and every data bit while `rst_wr_en` is low, leave the slot resets unchanged. Reset writes never affect `led_o`.
- R8: `rst_status_o` always equals `mod_rst_o`, bit for bit.
- R9: `sys_rst` clears every running one-shot and ignores reset writes made while it is high. At the first edge after `sys_rst` falls, each slot reset drops unless that same edge carries a write for that slot.
- R10: A reset write to a slot whose reset is already running restarts the full `RST_CYCLES` count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| sys_rst | input | 1 | Synchronous active-high system reset |
| sel_i | input | 6 | Target select strobes; bits 0-4 slots A-E, bit 5 carrier registers |
| rst_wr_en | input | 1 | Reset command write strobe |
| rst_wr_data | input | 5 | Reset command; bit i triggers slot i |
| led_o | output | 6 | Stretched access indicator drives |
| mod_rst_o | output | 5 | Per-slot module reset lines, active high |
| rst_status_o | output | 5 | Readable level of each slot reset line |

## Verification
The hardest case to reach is a system reset that lands in the middle of a running slot reset, and then a reset command written while the system reset is still high. From the ports this looks like "reset held high", whether the one-shot was cleared or not. The stimulus therefore starts a slot reset, asserts system reset part way through, writes a command during reset, and then releases. The next cycle shows whether the pulse survived or the write leaked through. Retriggering is covered by re-issuing selects and writes exactly one cycle before the pulse would end, where an off-by-one in the reload shows up as a one-cycle gap.

// File: rtl/aps_pkg.sv
package aps_pkg;
  localparam int SLOT_COUNT   = 5;
  localparam int TARGET_COUNT = SLOT_COUNT + 1;
  localparam int CARRIER_IDX  = SLOT_COUNT;

  typedef logic [SLOT_COUNT-1:0]   slot_vec_t;
  typedef logic [TARGET_COUNT-1:0] target_vec_t;
endpackage

// File: rtl/aps_oneshot.sv
module aps_oneshot #(
  parameter int WIDTH = 4,
  parameter bit HOLD  = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic pulse_o
);
  localparam int CW = $clog2(WIDTH + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain  <= '0;
      pulse_o <= HOLD;
    end else if (trig) begin
      remain  <= CW'(WIDTH - 1);
      pulse_o <= 1'b1;
    end else if (remain != '0) begin
      remain  <= remain - 1'b1;
      pulse_o <= 1'b1;
    end else begin
      pulse_o <= 1'b0;
    end
  end
endmodule

// File: rtl/aps_led_bank.sv
module aps_led_bank
  import aps_pkg::*;
#(
  parameter int LED_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  target_vec_t sel,
  output target_vec_t led
);
  for (genvar t = 0; t < TARGET_COUNT; t++) begin : g_led
    aps_oneshot #(.WIDTH(LED_CYCLES), .HOLD(1'b0)) u_shot (
      .clk     (clk),
      .rst     (rst),
      .trig    (sel[t]),
      .pulse_o (led[t])
    );
  end
endmodule

// File: rtl/aps_reset_bank.sv
module aps_reset_bank
  import aps_pkg::*;
#(
  parameter int RST_CYCLES = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_en,
  input  slot_vec_t wr_data,
  output slot_vec_t mod_rst
);
  slot_vec_t fire;

  always_comb fire = wr_data & {SLOT_COUNT{wr_en}};

  for (genvar s = 0; s < SLOT_COUNT; s++) begin : g_slot
    aps_oneshot #(.WIDTH(RST_CYCLES), .HOLD(1'b1)) u_shot (
      .clk     (clk),
      .rst     (rst),
      .trig    (fire[s]),
      .pulse_o (mod_rst[s])
    );
  end
endmodule

// File: rtl/access_led_reset_ctrl.sv
module access_led_reset_ctrl
  import aps_pkg::*;
#(
  parameter int LED_CYCLES = 400_000,
  parameter int RST_CYCLES = 1_600_000
) (
  input  logic       clk,
  input  logic       sys_rst,
  input  logic [5:0] sel_i,
  input  logic       rst_wr_en,
  input  logic [4:0] rst_wr_data,
  output logic [5:0] led_o,
  output logic [4:0] mod_rst_o,
  output logic [4:0] rst_status_o
);
  target_vec_t led_w;
  slot_vec_t   rst_w;

  aps_led_bank #(.LED_CYCLES(LED_CYCLES)) u_leds (
    .clk (clk),
    .rst (sys_rst),
    .sel (sel_i),
    .led (led_w)
  );

  aps_reset_bank #(.RST_CYCLES(RST_CYCLES)) u_resets (
    .clk     (clk),
    .rst     (sys_rst),
    .wr_en   (rst_wr_en),
    .wr_data (rst_wr_data),
    .mod_rst (rst_w)
  );

  assign led_o        = led_w;
  assign mod_rst_o    = rst_w;
  assign rst_status_o = rst_w;
endmodule

// File: rtl/access_led_reset_ctrl_chk.sv
module access_led_reset_ctrl_chk (
  input logic       clk,
  input logic       sys_rst,
  input logic [5:0] sel_i,
  input logic       rst_wr_en,
  input logic [4:0] rst_wr_data,
  input logic [5:0] led_o,
  input logic [4:0] mod_rst_o,
  input logic [4:0] rst_status_o
);
  p_sysrst_hold_r1: assert property (@(posedge clk)
    sys_rst |=> (led_o == 6'b0 && mod_rst_o == 5'h1F));

  p_sel_lights_r2: assert property (@(posedge clk) disable iff (sys_rst)
    (sel_i != 6'b0) |=> ((led_o & $past(sel_i)) == $past(sel_i)));

  p_no_early_off_r3: assert property (@(posedge clk) disable iff (sys_rst)
    ((~led_o & $past(led_o) & $past(sel_i)) == 6'b0));

  p_no_stray_on_r4: assert property (@(posedge clk) disable iff (sys_rst)
    ((led_o & ~$past(led_o) & ~$past(sel_i)) == 6'b0));

  p_write_fires_r5: assert property (@(posedge clk) disable iff (sys_rst)
    rst_wr_en |=> ((mod_rst_o & $past(rst_wr_data)) == $past(rst_wr_data)));

  p_no_stray_rst_r7: assert property (@(posedge clk) disable iff (sys_rst)
    ($past(sys_rst) || ((mod_rst_o & ~$past(mod_rst_o) &
      ~($past(rst_wr_data) & {5{$past(rst_wr_en)}})) == 5'b0)));

  p_status_match_r8: assert property (@(posedge clk)
    rst_status_o == mod_rst_o);
endmodule

bind access_led_reset_ctrl access_led_reset_ctrl_chk u_chk (
  .clk          (clk),
  .sys_rst      (sys_rst),
  .sel_i        (sel_i),
  .rst_wr_en    (rst_wr_en),
  .rst_wr_data  (rst_wr_data),
  .led_o        (led_o),
  .mod_rst_o    (mod_rst_o),
  .rst_status_o (rst_status_o)
);

// File: tb/tb_access_led_reset_ctrl.sv
module tb_access_led_reset_ctrl;
  localparam int LW = 4;
  localparam int RW = 10;

  logic       clk = 1'b0;
  logic       sys_rst = 1'b1;
  logic [5:0] sel_i = '0;
  logic       rst_wr_en = 1'b0;
  logic [4:0] rst_wr_data = '0;
  logic [5:0] led_o;
  logic [4:0] mod_rst_o;
  logic [4:0] rst_status_o;

  access_led_reset_ctrl #(.LED_CYCLES(LW), .RST_CYCLES(RW)) dut (
    .clk(clk), .sys_rst(sys_rst), .sel_i(sel_i), .rst_wr_en(rst_wr_en),
    .rst_wr_data(rst_wr_data), .led_o(led_o), .mod_rst_o(mod_rst_o),
    .rst_status_o(rst_status_o)
  );

  always #5 clk = ~clk;

  int led_rem [6];
  int rst_rem [5];
  logic [10:0] exp_q [$];
  string       tag_q [$];
  int applied = 0;
  int errors  = 0;
  bit done    = 0;

  task automatic step(input logic r, input logic [5:0] s, input logic we,
                      input logic [4:0] wd, input string tag);
    logic [5:0] el;
    logic [4:0] er;
    @(negedge clk);
    sys_rst = r; sel_i = s; rst_wr_en = we; rst_wr_data = wd;
    for (int i = 0; i < 6; i++) begin
      if (r) led_rem[i] = 0;
      else if (s[i]) led_rem[i] = LW;
      else if (led_rem[i] > 0) led_rem[i]--;
      el[i] = (led_rem[i] > 0);
    end
    for (int i = 0; i < 5; i++) begin
      if (r) rst_rem[i] = 0;
      else if (we && wd[i]) rst_rem[i] = RW;
      else if (rst_rem[i] > 0) rst_rem[i]--;
      er[i] = r || (rst_rem[i] > 0);
    end
    exp_q.push_back({el, er});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int k = 0; k < n; k++) step(1'b0, 6'b0, 1'b0, 5'b0, tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [10:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      applied++;
      if (led_o !== e[10:5] || mod_rst_o !== e[4:0] || rst_status_o !== e[4:0]) begin
        errors++;
        $display("FAIL %s: led=%b/%b rst=%b/%b status=%b/%b (actual/expected)",
                 t, led_o, e[10:5], mod_rst_o, e[4:0], rst_status_o, e[4:0]);
      end
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) led_rem[i] = 0;
    for (int i = 0; i < 5; i++) rst_rem[i] = 0;
    // R1 reset state
    for (int k = 0; k < 3; k++) step(1'b1, 6'b0, 1'b0, 5'b0, "R1");
    idle(2, "R9");
    // R2 single strobes, slot A and carrier
    step(1'b0, 6'b000001, 1'b0, 5'b0, "R2");
    idle(6, "R2");
    step(1'b0, 6'b100000, 1'b0, 5'b0, "R2");
    idle(6, "R2");
    // R3 retrigger one cycle before the end, then held select
    step(1'b0, 6'b000010, 1'b0, 5'b0, "R3");
    idle(LW - 1, "R3");
    step(1'b0, 6'b000010, 1'b0, 5'b0, "R3");
    idle(LW + 2, "R3");
    for (int k = 0; k < 8; k++) step(1'b0, 6'b000100, 1'b0, 5'b0, "R3");
    idle(LW + 2, "R3");
    // R4 independent targets
    step(1'b0, 6'b101010, 1'b0, 5'b0, "R4");
    step(1'b0, 6'b000000, 1'b0, 5'b0, "R4");
    step(1'b0, 6'b010001, 1'b0, 5'b0, "R4");
    idle(LW + 2, "R4");
    // R5 single slot reset; R8 status tracked on every vector
    step(1'b0, 6'b0, 1'b1, 5'b01000, "R5");
    idle(RW + 2, "R8");
    // R6 all slots at once
    step(1'b0, 6'b0, 1'b1, 5'b11111, "R6");
    idle(RW + 2, "R6");
    // R7 write enable low ignored; write leaves LEDs and clear bits alone
    for (int k = 0; k < 3; k++) step(1'b0, 6'b0, 1'b0, 5'b11111, "R7");
    step(1'b0, 6'b0, 1'b1, 5'b00100, "R7");
    idle(RW + 2, "R7");
    // R10 reset retrigger one cycle before end
    step(1'b0, 6'b0, 1'b1, 5'b00010, "R10");
    idle(RW - 1, "R10");
    step(1'b0, 6'b0, 1'b1, 5'b00010, "R10");
    idle(RW + 2, "R10");
    // R9 system reset mid pulse, write during reset, release
    step(1'b0, 6'b000011, 1'b1, 5'b10001, "R9");
    idle(2, "R9");
    step(1'b1, 6'b0, 1'b0, 5'b0, "R9");
    step(1'b1, 6'b001000, 1'b1, 5'b11111, "R9");
    idle(RW + 2, "R9");
    // R9 release coinciding with a write
    step(1'b1, 6'b0, 1'b0, 5'b0, "R9");
    step(1'b0, 6'b0, 1'b1, 5'b00001, "R9");
    idle(RW + 2, "R9");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
      $finish;
    end
  end
endmodule